// File: doc/BRIEF.md
# Change-Triggered Interrupt Collector with Message Output

This block gathers up to eleven asynchronous interrupt lines into a single outgoing write-message request towards a host. Each line is first brought into the local clock domain, then watched for transitions. When a line that software has enabled changes state, the block latches what happened and raises one message on a valid/ready port. The message carries a 32-bit word that software programmed beforehand, holding the target address OR-ed with the message data.

Software sees five word-wide registers through a simple strobe interface: the message word, the enable mask, a read-to-clear request register that collects enabled rising edges, a read-to-clear pending register that collects enabled changes in either direction, and a live level view of the synchronized lines. Messages are raised on transitions and not on steady levels. Software can still get level-triggered behaviour by reading the live levels after it services the latched state.

Register select codes on `reg_addr`: 0 message word, 1 enable mask, 2 request, 3 pending, 4 live levels. Any other code reads as zero. Writes take effect only at codes 0 and 1.

Top module: `irq_msg_aggregator`

## Requirements
- R1: After reset, the message word, mask, request and pending registers read as zero and `msg_valid` is low.
- R2: A write to code 0 stores all 32 bits. Reading code 0 returns them. Every raised message presents the stored word on `msg_data`.
- R3: Bit n of the mask (code 1) enables line n. Only the implemented set 0x5ff can be stored, which is bits 0 to 8 and bit 10. Bit 9 always reads 0 and line 9 never sets a request or pending bit and never raises a message.
- R4: A request bit (code 2) sets on a rising edge of an enabled line. A falling edge, or any edge on a masked line, leaves it unchanged.
- R5: A read of code 2 returns the request bits and clears them at the same clock edge. A rising edge that registers at that same edge stays set after the clear.
- R6: A pending bit (code 3) sets on any change of an enabled line, rising or falling. A read returns the bits and clears them, and it does not alter the level view.
- R7: Code 4 shows the synchronized live level of every line, whatever the mask.
- R8: An enabled change raises `msg_valid`. It stays high, with `msg_data` stable, until a cycle with `msg_ready` high.
- R9: Enabled changes seen while a message waits for `msg_ready` are merged into it. After the handshake no further message follows unless a new change arrives.
- R10: A line that is already high when its mask bit becomes set raises no message and sets no request bit.
- R11: A line change driven before clock edge k shows in the level view after edge k+1. It shows in the request, pending and message outputs after edge k+2, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | 11 | Asynchronous interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; read-to-clear takes effect at the edge |
| reg_addr | input | 3 | Register select code |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle `reg_rd` is high |
| msg_valid | output | 1 | Outgoing message request |
| msg_ready | input | 1 | Host accepts the message |
| msg_data | output | 32 | Message word (address OR data) |

## Verification
A sweep raises and then lowers each of the eleven lines in turn with every implemented mask bit set. It separates rising edges, which set both request and pending bits, from falling edges, which set pending only, and it shows that line 9 stays silent. Further patterns cover two lines changing while a message waits, to show the merge, and a read placed in the same cycle as a new edge. A line that is held high while it is unmasked checks that the block reacts to transitions and not to levels. Checks taken one edge early and exactly on time pin down the synchronizer latency.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
    typedef enum logic [2:0] {
        SEL_TARGET = 3'd0,
        SEL_MASK   = 3'd1,
        SEL_REQ    = 3'd2,
        SEL_PEND   = 3'd3,
        SEL_LEVEL  = 3'd4
    } reg_sel_e;
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
    parameter int N = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lines_in,
    output logic [N-1:0] level,
    output logic [N-1:0] rise,
    output logic [N-1:0] change
);
    typedef struct packed {
        logic [N-1:0] s1;
        logic [N-1:0] s2;
        logic [N-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = lines_in;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level  = st_q.s2;
    assign change = st_q.s2 ^ st_q.prev;
    assign rise   = st_q.s2 & ~st_q.prev;

    // cycles since reset, so the latency check never looks across reset
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)               warm_q <= '0;
        else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
    end

    // R11
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3) |-> (level == $past(lines_in, 2)));
endmodule

// File: rtl/irq_reg_file.sv
module irq_reg_file
    import irq_agg_pkg::*;
#(
    parameter int           N    = 11,
    parameter int           DW   = 32,
    parameter int           AW   = 3,
    parameter logic [N-1:0] IMPL = 11'h5ff
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          rd,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    input  logic [N-1:0]  level,
    input  logic [N-1:0]  rise,
    input  logic [N-1:0]  change,
    output logic [DW-1:0] target,
    output logic          event_any
);
    typedef struct packed {
        logic [DW-1:0] target;
        logic [N-1:0]  mask;
        logic [N-1:0]  req;
        logic [N-1:0]  pend;
    } regs_t;

    regs_t st_d, st_q;

    logic [N-1:0] ev_req, ev_pend;
    logic         rd_req, rd_pend;

    always_comb begin
        ev_req  = rise   & st_q.mask & IMPL;
        ev_pend = change & st_q.mask & IMPL;
        rd_req  = rd && (addr == AW'(SEL_REQ));
        rd_pend = rd && (addr == AW'(SEL_PEND));

        st_d = st_q;
        if (wr && addr == AW'(SEL_TARGET)) st_d.target = wdata;
        if (wr && addr == AW'(SEL_MASK))   st_d.mask   = wdata[N-1:0] & IMPL;
        st_d.req  = (rd_req  ? '0 : st_q.req)  | ev_req;
        st_d.pend = (rd_pend ? '0 : st_q.pend) | ev_pend;

        rdata = '0;
        if (rd) begin
            case (addr)
                AW'(SEL_TARGET): rdata = st_q.target;
                AW'(SEL_MASK):   rdata = DW'(st_q.mask);
                AW'(SEL_REQ):    rdata = DW'(st_q.req);
                AW'(SEL_PEND):   rdata = DW'(st_q.pend);
                AW'(SEL_LEVEL):  rdata = DW'(level);
                default:         rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign target    = st_q.target;
    assign event_any = |ev_pend;

    // R5
    req_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rise == '0) |=> (st_q.req == '0));

    // R6
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pend && change == '0) |=> (st_q.pend == '0));

    // R3
    req_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.req & ~$past(st_q.req) & ~$past(st_q.mask)) == '0));

    // R4
    req_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_req && rise == '0) |=> (st_q.req == $past(st_q.req)));
endmodule

// File: rtl/irq_msg_port.sv
module irq_msg_port #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          event_any,
    input  logic [DW-1:0] payload,
    output logic          valid,
    input  logic          ready,
    output logic [DW-1:0] data
);
    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
    } msg_t;

    msg_t st_d, st_q;
    logic waiting;

    always_comb begin
        waiting = st_q.valid && !ready;
        st_d    = st_q;
        if (waiting) begin
            st_d.valid = 1'b1;          // later changes merge into this one
        end else if (event_any) begin
            st_d.valid = 1'b1;
            st_d.data  = payload;
        end else begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign data  = st_q.data;

    // R8
    msg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !ready) |=> (valid && $stable(data)));

    // R8
    msg_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        event_any |=> valid);

    // R9
    msg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready && !event_any) |=> !valid);
endmodule

// File: rtl/irq_msg_aggregator.sv
module irq_msg_aggregator #(
    parameter int           N    = 11,
    parameter int           DW   = 32,
    parameter int           AW   = 3,
    parameter logic [N-1:0] IMPL = 11'h5ff
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  irq_lines,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          msg_valid,
    input  logic          msg_ready,
    output logic [DW-1:0] msg_data
);
    logic [N-1:0]  level, rise, change;
    logic [DW-1:0] target;
    logic          event_any;

    irq_edge_sync #(.N(N)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .lines_in (irq_lines),
        .level    (level),
        .rise     (rise),
        .change   (change)
    );

    irq_reg_file #(.N(N), .DW(DW), .AW(AW), .IMPL(IMPL)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .rd        (reg_rd),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .level     (level),
        .rise      (rise),
        .change    (change),
        .target    (target),
        .event_any (event_any)
    );

    irq_msg_port #(.DW(DW)) u_msg (
        .clk       (clk),
        .rst_n     (rst_n),
        .event_any (event_any),
        .payload   (target),
        .valid     (msg_valid),
        .ready     (msg_ready),
        .data      (msg_data)
    );
endmodule

// File: tb/irq_msg_aggregator_test.sv
module irq_msg_aggregator_test;
    localparam logic [10:0] IMPL = 11'h5ff;
    localparam logic [31:0] WORD = 32'h8000_1005;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] lines = '0;
    logic        wr = 1'b0, rd = 1'b0, ready = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0, rdata, mdata;
    logic        mvalid;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    irq_msg_aggregator uut (
        .clk(clk), .rst_n(rst_n), .irq_lines(lines),
        .reg_wr(wr), .reg_rd(rd), .reg_addr(addr), .reg_wdata(wdata),
        .reg_rdata(rdata), .msg_valid(mvalid), .msg_ready(ready),
        .msg_data(mdata)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr = 1'b1;
        wait_edges(1);
        wr = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
        addr = a; rd = 1'b1;
        #1 d = rdata;
        wait_edges(1);
        rd = 1'b0;
    endtask

    task automatic consume();
        ready = 1'b1;
        wait_edges(1);
        ready = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        wait_edges(3);
        rst_n = 1'b1;
        wait_edges(1);
        // R1 reset state
        chk("R1 valid", {31'd0, mvalid}, 32'd0);
        reg_read(3'd0, v); chk("R1 target", v, 32'd0);
        reg_read(3'd1, v); chk("R1 mask", v, 32'd0);
        reg_read(3'd2, v); chk("R1 req", v, 32'd0);
        reg_read(3'd3, v); chk("R1 pend", v, 32'd0);

        // R2 message word
        reg_write(3'd0, WORD);
        reg_read(3'd0, v); chk("R2 target readback", v, WORD);
        // R3 mask store limited to implemented set
        reg_write(3'd1, 32'hffff_ffff);
        reg_read(3'd1, v); chk("R3 mask readback", v, 32'h5ff);

        // sweep every line: rise then fall
        for (int i = 0; i < 11; i++) begin
            lines[i] = 1'b1;
            wait_edges(3);
            reg_read(3'd4, v); chk("R7 level after rise", v, 32'(1) << i);
            chk("R8 msg on rise", {31'd0, mvalid}, {31'd0, IMPL[i]});
            if (mvalid) chk("R2 msg data", mdata, WORD);
            reg_read(3'd2, v); chk("R4 req on rise", v, IMPL[i] ? (32'(1) << i) : 32'd0);
            reg_read(3'd2, v); chk("R5 req cleared", v, 32'd0);
            reg_read(3'd3, v); chk("R6 pend on rise", v, IMPL[i] ? (32'(1) << i) : 32'd0);
            reg_read(3'd4, v); chk("R6 level kept after pend read", v, 32'(1) << i);
            if (mvalid) consume();
            chk("R9 no second msg", {31'd0, mvalid}, 32'd0);
            lines[i] = 1'b0;
            wait_edges(3);
            chk("R8 msg on fall", {31'd0, mvalid}, {31'd0, IMPL[i]});
            reg_read(3'd2, v); chk("R4 no req on fall", v, 32'd0);
            reg_read(3'd3, v); chk("R6 pend on fall", v, IMPL[i] ? (32'(1) << i) : 32'd0);
            if (mvalid) consume();
        end

        // R11 latency: not visible after edge k+1, visible after k+2
        lines[4] = 1'b1;
        wait_edges(2);
        chk("R11 msg not early", {31'd0, mvalid}, 32'd0);
        wait_edges(1);
        chk("R11 msg on time", {31'd0, mvalid}, 32'd1);
        // R9 second change while waiting merges
        lines[5] = 1'b1;
        wait_edges(4);
        chk("R9 still waiting", {31'd0, mvalid}, 32'd1);
        consume();
        wait_edges(2);
        chk("R9 merged single msg", {31'd0, mvalid}, 32'd0);
        reg_read(3'd3, v); chk("R9 pend merged", v, 32'h30);
        reg_read(3'd2, v); chk("R9 req merged", v, 32'h30);

        // R5 read in the same cycle a new rising edge registers
        lines[0] = 1'b1;
        wait_edges(3);
        consume();
        lines[1] = 1'b1;                 // registers at the 3rd edge from here
        wait_edges(2);
        reg_read(3'd2, v); chk("R5 read value", v, 32'h1);
        reg_read(3'd2, v); chk("R5 new edge survives clear", v, 32'h2);
        if (mvalid) consume();
        reg_read(3'd3, v);
        lines = '0;
        wait_edges(3);
        if (mvalid) consume();
        reg_read(3'd3, v);

        // R10 line high when unmasked
        reg_write(3'd1, 32'd0);
        lines[3] = 1'b1;
        wait_edges(3);
        chk("R10 masked no msg", {31'd0, mvalid}, 32'd0);
        reg_read(3'd4, v); chk("R7 level ignores mask", v, 32'h8);
        reg_write(3'd1, 32'h8);
        wait_edges(3);
        chk("R10 unmask no msg", {31'd0, mvalid}, 32'd0);
        reg_read(3'd2, v); chk("R10 unmask no req", v, 32'd0);
        // R3 line 9 never reports even if requested in mask
        reg_write(3'd1, 32'h200);
        lines[9] = 1'b1;
        wait_edges(3);
        chk("R3 line9 no msg", {31'd0, mvalid}, 32'd0);
        reg_read(3'd3, v); chk("R3 line9 no pend", v, 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule